// File: doc/BRIEF.md
# Timed FIR Selection Table

This block keeps, for every pairing of an output beam with an antenna input, the number of the coefficient set that a downstream FIR matrix should apply to that contribution. Software posts selections through plain write strobes that carry a beam, an antenna and a filter number. Each selection is stamped with the current control time and queued. It takes effect once a free-running time counter reaches that stamp. A stamp of zero means "as soon as possible".

The whole table is presented at once on a wide parallel port, so the FIR matrix can pick up its configuration without any handshake. Selections that share a stamp form a batch, and the batch becomes visible in a single step, so the matrix never runs on a half-applied set of filters. A readback port returns the last accepted selection for any slot, and the control time register can also be read back.

The block has no streaming interface and no back-pressure. Writes are never stalled. A selection that arrives while the queue is full is discarded, and a sticky flag records the loss.

Top module: `ftab_timed_select`

## Requirements
- R1: The slot of a selection is beam*NUM_ANTS + antenna, so with the default geometry there are 160 slots. Slot s occupies `table_o[s*FIDX_W +: FIDX_W]`. FIDX_W defaults to 12 bits, so filter numbers such as 357 fit.
- R2: A write to the control time register is returned on `ctl_time_o` from the next cycle. That value stamps every selection accepted afterwards, until the register is written again.
- R3: When a selection is accepted at a clock edge, is stamped zero, and finds the queue empty, its slot changes on `table_o` at the second following edge.
- R4: A selection stamped T is never visible on `table_o` before `time_o` reads T+2.
- R5: Queued selections commit one per cycle, strictly in arrival order. An entry that is not yet due holds back every entry behind it, including entries stamped zero.
- R6: Consecutive queued selections with equal stamps change `table_o` in one single step, after the last of them has committed.
- R7: A selection written while FIFO_DEPTH entries are queued is discarded. It has no effect on the table or on readback. `overflow_o` rises on the next cycle and stays high until reset.
- R8: A selection whose beam is at least NUM_BEAMS, or whose antenna is at least NUM_ANTS, is ignored completely. A readback of such a pair returns 0.
- R9: `rd_fidx_o` combinationally returns the last accepted filter number for the slot given by `rd_beam`/`rd_ant`, even while that selection is still queued.
- R10: `time_o` is 0 in reset and increases by one every clock cycle.
- R11: After reset, every slot of `table_o` is 0, `overflow_o` is 0 and `ctl_time_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_time_we | input | 1 | Write strobe for the control time |
| ctl_time_wdata | input | 64 | New control time; 0 means immediate |
| ctl_time_o | output | 64 | Current control time |
| sel_we | input | 1 | Selection write strobe |
| sel_beam | input | BEAM_W (4) | Beam of the selection |
| sel_ant | input | ANT_W (4) | Antenna of the selection |
| sel_fidx | input | FIDX_W (12) | Filter number to apply |
| rd_beam | input | BEAM_W (4) | Readback beam |
| rd_ant | input | ANT_W (4) | Readback antenna |
| rd_fidx_o | output | FIDX_W (12) | Last accepted filter number for the readback slot |
| time_o | output | 64 | Free-running time counter |
| table_o | output | SLOTS*FIDX_W (1920) | Committed filter numbers of all slots |
| overflow_o | output | 1 | Sticky flag for a discarded selection |

## Verification
The bench keeps the default 10-beam by 16-antenna geometry. This lets it reach the last slot (beam 9, antenna 15), the first out-of-range beam value, and the slot holding 357. The queue depth is reduced to 4, so a full queue, the discarded fifth write and a batch that fills the whole queue are all reached within a few dozen cycles. The stamps are set only tens of cycles ahead, which keeps the time windows short while still separating "not yet due" from "committed".

// File: rtl/ftab_pkg.sv
package ftab_pkg;
  localparam int TS_W = 64;
  typedef logic [TS_W-1:0] ts_t;

  // An entry is due when its stamp is zero or the counter has reached it.
  function automatic logic ts_due(input ts_t now, input ts_t stamp);
    return (stamp == '0) || (now >= stamp);
  endfunction
endpackage

// File: rtl/ftab_clock_count.sv
module ftab_clock_count #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now_o
);
  logic [W-1:0] now_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  assign now_o = now_q;
endmodule

// File: rtl/ftab_sel_fifo.sv
module ftab_sel_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [W-1:0]     next_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= bump(wp_q);
      if (pop_i)  rp_q <= bump(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rp_q];
  assign next_o  = mem_q[bump(rp_q)];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/ftab_slot_table.sv
module ftab_slot_table #(
  parameter int SLOTS = 160,
  parameter int FW    = 12,
  parameter int AW    = 8,
  localparam int TW   = SLOTS * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          note_we_i,
  input  logic [AW-1:0] note_addr_i,
  input  logic [FW-1:0] note_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [FW-1:0] rd_data_o,
  input  logic          stage_we_i,
  input  logic [AW-1:0] stage_addr_i,
  input  logic [FW-1:0] stage_data_i,
  input  logic          publish_i,
  output logic [TW-1:0] live_o
);
  // note: last accepted write per slot; stage: committed, not yet shown;
  // live: what the FIR matrix sees.
  logic [FW-1:0] note_q  [SLOTS];
  logic [FW-1:0] stage_q [SLOTS];
  logic [FW-1:0] live_q  [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) note_q[i] <= '0;
    end else if (note_we_i) begin
      note_q[note_addr_i] <= note_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) stage_q[i] <= '0;
    end else if (stage_we_i) begin
      stage_q[stage_addr_i] <= stage_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) live_q[i] <= '0;
    end else if (publish_i) begin
      for (int i = 0; i < SLOTS; i++) live_q[i] <= stage_q[i];
    end
  end

  assign rd_data_o = note_q[rd_addr_i];

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign live_o[g*FW +: FW] = live_q[g];
  end
endmodule

// File: rtl/ftab_timed_select.sv
module ftab_timed_select
  import ftab_pkg::*;
#(
  parameter int NUM_BEAMS  = 10,
  parameter int NUM_ANTS   = 16,
  parameter int FIDX_W     = 12,
  parameter int FIFO_DEPTH = 16,
  localparam int BEAM_W = (NUM_BEAMS > 1) ? $clog2(NUM_BEAMS) : 1,
  localparam int ANT_W  = (NUM_ANTS > 1) ? $clog2(NUM_ANTS) : 1,
  localparam int SLOTS  = NUM_BEAMS * NUM_ANTS,
  localparam int TBL_W  = SLOTS * FIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_time_we,
  input  logic [TS_W-1:0]   ctl_time_wdata,
  output logic [TS_W-1:0]   ctl_time_o,
  input  logic              sel_we,
  input  logic [BEAM_W-1:0] sel_beam,
  input  logic [ANT_W-1:0]  sel_ant,
  input  logic [FIDX_W-1:0] sel_fidx,
  input  logic [BEAM_W-1:0] rd_beam,
  input  logic [ANT_W-1:0]  rd_ant,
  output logic [FIDX_W-1:0] rd_fidx_o,
  output logic [TS_W-1:0]   time_o,
  output logic [TBL_W-1:0]  table_o,
  output logic              overflow_o
);
  localparam int IDX_W = BEAM_W + ANT_W;
  localparam int E_W   = TS_W + IDX_W + FIDX_W;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  ts_t               now_q;
  ts_t               ctl_time_q;
  logic              ovf_q;
  logic              pub_q;

  logic              sel_ok, rd_ok;
  logic [IDX_W-1:0]  wslot, rslot, rd_addr;
  logic [E_W-1:0]    wr_entry, head, next;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_full, fifo_empty;
  logic              push, pop, batch_end;
  ts_t               head_ts, next_ts;
  logic [IDX_W-1:0]  head_slot;
  logic [FIDX_W-1:0] head_fidx, rd_raw;

  // ---------------- slot addressing ----------------
  assign sel_ok = ({1'b0, sel_beam} < (BEAM_W+1)'(NUM_BEAMS)) &&
                  ({1'b0, sel_ant}  < (ANT_W+1)'(NUM_ANTS));
  assign rd_ok  = ({1'b0, rd_beam}  < (BEAM_W+1)'(NUM_BEAMS)) &&
                  ({1'b0, rd_ant}   < (ANT_W+1)'(NUM_ANTS));
  assign wslot  = IDX_W'(sel_beam) * IDX_W'(NUM_ANTS) + IDX_W'(sel_ant);
  assign rslot  = IDX_W'(rd_beam)  * IDX_W'(NUM_ANTS) + IDX_W'(rd_ant);
  assign rd_addr   = rd_ok ? rslot : '0;
  assign rd_fidx_o = rd_ok ? rd_raw : '0;

  // ---------------- time base ----------------
  ftab_clock_count #(.W(TS_W)) u_clock (
    .clk   (clk),
    .rst_n (rst_n),
    .now_o (now_q)
  );

  // ---------------- control time register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctl_time_q <= '0;
    else if (ctl_time_we) ctl_time_q <= ctl_time_wdata;
  end

  // ---------------- pending queue ----------------
  assign push     = sel_we && sel_ok && !fifo_full;
  assign wr_entry = {ctl_time_q, wslot, sel_fidx};

  ftab_sel_fifo #(.W(E_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .data_i  (wr_entry),
    .pop_i   (pop),
    .head_o  (head),
    .next_o  (next),
    .count_o (fifo_count),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  assign head_ts   = head[E_W-1 -: TS_W];
  assign head_slot = head[FIDX_W +: IDX_W];
  assign head_fidx = head[FIDX_W-1:0];
  assign next_ts   = next[E_W-1 -: TS_W];

  // ---------------- commit sequencing ----------------
  assign pop       = !fifo_empty && ts_due(now_q, head_ts);
  assign batch_end = (fifo_count == CNT_W'(1)) || (next_ts != head_ts);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pub_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      pub_q <= pop && batch_end;
      if (sel_we && sel_ok && fifo_full) ovf_q <= 1'b1;
    end
  end

  // ---------------- storage ----------------
  ftab_slot_table #(.SLOTS(SLOTS), .FW(FIDX_W), .AW(IDX_W)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .note_we_i    (push),
    .note_addr_i  (wslot),
    .note_data_i  (sel_fidx),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_raw),
    .stage_we_i   (pop),
    .stage_addr_i (head_slot),
    .stage_data_i (head_fidx),
    .publish_i    (pub_q),
    .live_o       (table_o)
  );

  assign ctl_time_o = ctl_time_q;
  assign time_o     = now_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/ftab_timed_select_chk.sv
module ftab_timed_select_chk #(
  parameter int TBL_W = 1920,
  parameter int CNT_W = 5,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [63:0]      now_i,
  input logic             ctl_we_i,
  input logic [63:0]      ctl_wdata_i,
  input logic [63:0]      ctl_time_i,
  input logic             sel_we_i,
  input logic             sel_ok_i,
  input logic             full_i,
  input logic [CNT_W-1:0] count_i,
  input logic             pop_i,
  input logic [63:0]      head_ts_i,
  input logic             pub_i,
  input logic             ovf_i,
  input logic [TBL_W-1:0] table_i
);
  assert_time_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (now_i != '1) |=> (now_i == $past(now_i) + 64'd1));

  assert_ctl_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i |=> (ctl_time_i == $past(ctl_wdata_i)));

  assert_pop_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> ((head_ts_i == 64'd0) || (now_i >= head_ts_i)));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(table_i) |-> $past(pub_i));

  assert_queue_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_i <= CNT_W'(DEPTH));

  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we_i && sel_ok_i && full_i) |=> ovf_i);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> ovf_i);
endmodule

bind ftab_timed_select ftab_timed_select_chk #(
  .TBL_W (TBL_W),
  .CNT_W (CNT_W),
  .DEPTH (FIFO_DEPTH)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .now_i       (now_q),
  .ctl_we_i    (ctl_time_we),
  .ctl_wdata_i (ctl_time_wdata),
  .ctl_time_i  (ctl_time_o),
  .sel_we_i    (sel_we),
  .sel_ok_i    (sel_ok),
  .full_i      (fifo_full),
  .count_i     (fifo_count),
  .pop_i       (pop),
  .head_ts_i   (head_ts),
  .pub_i       (pub_q),
  .ovf_i       (overflow_o),
  .table_i     (table_o)
);

// File: tb/ftab_timed_select_tb.sv
module ftab_timed_select_tb_top;
  localparam int NB  = 10;
  localparam int NA  = 16;
  localparam int FW  = 12;
  localparam int DEP = 4;
  localparam int SL  = NB * NA;
  localparam int TW  = SL * FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_time_we = 1'b0;
  logic [63:0]   ctl_time_wdata = '0;
  logic [63:0]   ctl_time_o;
  logic          sel_we = 1'b0;
  logic [3:0]    sel_beam = '0, sel_ant = '0;
  logic [FW-1:0] sel_fidx = '0;
  logic [3:0]    rd_beam = '0, rd_ant = '0;
  logic [FW-1:0] rd_fidx_o;
  logic [63:0]   time_o;
  logic [TW-1:0] table_o;
  logic          overflow_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int            mdl [SL];
  logic [TW-1:0] exp_q [$];
  logic [63:0]   exp_ts_q [$];
  logic [TW-1:0] prev_tbl;

  always #2.5 clk = ~clk;

  ftab_timed_select #(
    .NUM_BEAMS(NB), .NUM_ANTS(NA), .FIDX_W(FW), .FIFO_DEPTH(DEP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_time_we(ctl_time_we), .ctl_time_wdata(ctl_time_wdata), .ctl_time_o(ctl_time_o),
    .sel_we(sel_we), .sel_beam(sel_beam), .sel_ant(sel_ant), .sel_fidx(sel_fidx),
    .rd_beam(rd_beam), .rd_ant(rd_ant), .rd_fidx_o(rd_fidx_o),
    .time_o(time_o), .table_o(table_o), .overflow_o(overflow_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] snap();
    logic [TW-1:0] v;
    for (int i = 0; i < SL; i++) v[i*FW +: FW] = FW'(mdl[i]);
    return v;
  endfunction

  function automatic int slot_val(input int s);
    return int'(table_o[s*FW +: FW]);
  endfunction

  // driver tasks: entered and left at a falling edge
  task automatic put_time(input logic [63:0] t);
    ctl_time_we = 1'b1; ctl_time_wdata = t;
    @(negedge clk);
    ctl_time_we = 1'b0;
  endtask

  task automatic put_sel(input int b, input int a, input int f);
    sel_we = 1'b1; sel_beam = 4'(b); sel_ant = 4'(a); sel_fidx = FW'(f);
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic expect_tbl(input logic [63:0] ts);
    exp_q.push_back(snap());
    exp_ts_q.push_back(ts);
  endtask

  task automatic check_rb(input int b, input int a, input int e, input string req);
    rd_beam = 4'(b); rd_ant = 4'(a);
    #1;
    check(int'(rd_fidx_o) == e, req, int'(rd_fidx_o), e);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // monitor: every table change must match the next expected snapshot
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (table_o !== prev_tbl) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected table change", 1, 0);
        end else begin
          logic [TW-1:0] e;
          logic [63:0]   ets;
          int            ms;
          e = exp_q.pop_front();
          ets = exp_ts_q.pop_front();
          ms = -1;
          for (int i = SL - 1; i >= 0; i--)
            if (table_o[i*FW +: FW] !== e[i*FW +: FW]) ms = i;
          if (ms < 0) check(1'b1, "R6", 0, 0);
          else check(1'b0, "R6 snapshot slot mismatch", slot_val(ms), int'(e[ms*FW +: FW]));
          if (ets != 0)
            check(time_o >= ets + 2, "R4 commit time", longint'(time_o), longint'(ets + 2));
        end
      end
      prev_tbl = table_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ts, ts2;
    for (int i = 0; i < SL; i++) mdl[i] = 0;
    prev_tbl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state, R10 counter
    check(table_o == '0, "R11 table", 0, 0);
    check(overflow_o == 1'b0, "R11 overflow", overflow_o, 0);
    check(ctl_time_o == 0, "R11 ctl time", longint'(ctl_time_o), 0);
    ts = time_o;
    @(negedge clk);
    check(time_o == ts + 1, "R10 step", longint'(time_o), longint'(ts + 1));

    // R3 immediate commit, exact edge; R1 slot position
    mdl[1*16 + 0] = 357;
    expect_tbl(0);
    put_sel(1, 0, 357);
    check(slot_val(16) == 0, "R3 not before 2nd edge", slot_val(16), 0);
    @(negedge clk);
    check(slot_val(16) == 0, "R3 not before 2nd edge", slot_val(16), 0);
    @(negedge clk);
    check(slot_val(16) == 357, "R1 R3 slot 16", slot_val(16), 357);
    check_rb(1, 0, 357, "R9 readback");

    // immediate writes back to back, each its own step
    mdl[0] = 5;   expect_tbl(0); put_sel(0, 0, 5);
    mdl[159] = 4095; expect_tbl(0); put_sel(9, 15, 4095);
    drain("R3 drain");
    check(slot_val(159) == 4095, "R1 last slot", slot_val(159), 4095);

    // R2 R4 R6 timed batch of three, R9 readback before commit
    ts = time_o + 40;
    put_time(ts);
    check(ctl_time_o == ts, "R2 ctl readback", longint'(ctl_time_o), longint'(ts));
    mdl[2*16 + 3] = 100;
    mdl[5*16 + 7] = 200;
    mdl[9*16 + 15] = 300;
    expect_tbl(ts);
    put_sel(2, 3, 100);
    put_sel(5, 7, 200);
    put_sel(9, 15, 300);
    check_rb(5, 7, 200, "R9 queued readback");
    check(slot_val(5*16 + 7) == 0, "R4 not yet committed", slot_val(5*16 + 7), 0);
    drain("R6 batch");
    check(slot_val(159) == 300, "R6 batch value", slot_val(159), 300);

    // R5 two batches with different stamps, same slot rewritten in order
    ts = time_o + 30; ts2 = ts + 20;
    put_time(ts);
    mdl[3*16 + 3] = 11; mdl[3*16 + 3] = 12;
    expect_tbl(ts);
    put_sel(3, 3, 11);
    put_sel(3, 3, 12);
    put_time(ts2);
    mdl[4*16 + 4] = 21;
    expect_tbl(ts2);
    put_sel(4, 4, 21);
    drain("R5 ordered batches");
    check(slot_val(3*16 + 3) == 12, "R5 last write wins", slot_val(3*16 + 3), 12);

    // R5 zero stamp held behind a future head
    ts = time_o + 30;
    put_time(ts);
    mdl[6*16 + 1] = 61;
    expect_tbl(ts);
    put_sel(6, 1, 61);
    put_time(64'd0);
    mdl[6*16 + 2] = 62;
    expect_tbl(ts);
    put_sel(6, 2, 62);
    repeat (5) @(negedge clk);
    check(slot_val(6*16 + 2) == 0, "R5 zero stamp held", slot_val(6*16 + 2), 0);
    drain("R5 held drain");
    check(slot_val(6*16 + 2) == 62, "R5 released", slot_val(6*16 + 2), 62);

    // R7 overflow with a full batch of DEP entries
    ts = time_o + 60;
    put_time(ts);
    mdl[7*16 + 0] = 70; mdl[7*16 + 1] = 71; mdl[7*16 + 2] = 72; mdl[7*16 + 3] = 73;
    expect_tbl(ts);
    put_sel(7, 0, 70);
    put_sel(7, 1, 71);
    put_sel(7, 2, 72);
    put_sel(7, 3, 73);
    check(overflow_o == 1'b0, "R7 no overflow yet", overflow_o, 0);
    put_sel(8, 8, 999);
    check(overflow_o == 1'b1, "R7 overflow set", overflow_o, 1);
    check_rb(8, 8, 0, "R7 dropped readback");
    drain("R7 R6 full batch");
    check(slot_val(8*16 + 8) == 0, "R7 dropped not applied", slot_val(8*16 + 8), 0);
    check(overflow_o == 1'b1, "R7 sticky", overflow_o, 1);

    // R8 out-of-range beam ignored
    put_time(64'd0);
    put_sel(10, 0, 77);
    put_sel(15, 15, 78);
    repeat (6) @(negedge clk);
    check(table_o == snap(), "R8 table unchanged", 0, 0);
    check_rb(10, 0, 0, "R8 readback zero");
    check_rb(0, 0, 5, "R8 slot 0 intact");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 no pending", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule